// File: doc/BRIEF.md
# Reloadable Down-Counting Timer Channel

This block is one timer channel with a small block-control word in front of it. A counter is loaded from software and decrements once per selected tick. On reaching zero it raises a sticky status flag and, if enabled, an interrupt. The tick comes from one of several sources:

- a free-running reference pulse input;
- an external pin;
- every clock;
- nothing at all.

Each source passes through an optional power-of-two prescaler and a polarity inverter. In reload mode the counter refills from a stored fixed count and keeps running. Otherwise it parks at zero.

Software reaches the block through a plain write strobe and a combinational read port. Both control words have a set alias and a clear alias, so single bits change without a read-modify-write. A count write always stores the fixed value. When the update bit is on, the same write also loads the live counter. A count read returns the live count in the upper half, which software can invert to get a rising timestamp.

Top module: `dtimer_channel`

## Requirements
- R1: After reset the block word reads 0xC000_0000 (bit 31 soft reset, bit 30 clock gate), the channel word and count word read zero, and `irq` is low.
- R2: While soft reset is set, all channel state (control fields, counts, prescaler, status flag) is held at zero and writes to the channel and count words are ignored. Writing 0xC000_0000 to the block clear alias (0x08) restarts the block.
- R3: While the clock gate bit is set, the live count and prescaler do not advance. Register writes still take effect.
- R4: The select field (channel bits 3:0) works as follows: code 0 never ticks, code 1 ticks on a rising edge of `extTick`, code 8 ticks on a rising edge of `refTick`, and code 15 ticks every clock. All other codes never tick.
- R5: Polarity (channel bit 6) inverts the selected pin before rising-edge detection.
- R6: Prescale (channel bits 5:4, value p) passes one tick per 2^p source pulses. Any write to the channel word restarts the prescaler.
- R7: Each tick decrements the live count by one. With reload (channel bit 8) clear, a tick at zero leaves the count at zero.
- R8: With reload set, a tick at zero loads the fixed count, so a fixed count of N-1 gives a period of N ticks.
- R9: A write to the count word (0x20) stores bits 15:0 as the fixed count. If update (channel bit 7) is set, the same write loads the live count, and this takes priority over a tick in that cycle. A read of 0x20 returns {live, fixed}, so 0xFFFF is the largest count.
- R10: The status flag (channel bit 15) sets on any tick that leaves the count at zero, except a tick at zero with reload clear. The flag stays set until a one is written to bit 15 through the channel clear alias. A set in the same cycle wins over the clear.
- R11: `irq` is high exactly when the status flag and interrupt enable (channel bit 14) are both high.
- R12: Offset +0 of the block word (0x00) and of the channel word (0x10) replaces the word, +4 ORs data into it, and +8 clears the data's one bits. Reads at any of the three offsets return the word. Only the clear alias changes the status flag. Unmapped reads return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe |
| addr | input | 8 | Byte address for read and write |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Combinational read data for `addr` |
| extTick | input | 1 | External tick pin |
| refTick | input | 1 | Reference tick pulse input |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: a 16-bit count, which places the 0xFFFF extreme in the upper read half, and a 2-bit prescale, which allows a division of up to eight. At these sizes every prescale value, both pin sources with either polarity, reload wrap-around and the stop-at-zero case complete within a few dozen cycles each. A behavioural model tracks every field and is compared with `irq` on every clock and with `rdData` at each read. The full-scale count is checked by reading right after loading it.

// File: rtl/dtimer_pkg.sv
package dtimer_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int CNT_W  = DATA_W / 2;
  localparam int PRE_W  = 2;
  localparam int SEL_W  = 4;

  // address pages (addr[7:4]) and alias kinds (addr[3:2])
  localparam int PAGE_BLK = 0;
  localparam int PAGE_CH  = 1;
  localparam int PAGE_CNT = 2;
  localparam logic [1:0] KIND_WRITE = 2'd0;
  localparam logic [1:0] KIND_SET   = 2'd1;
  localparam logic [1:0] KIND_CLR   = 2'd2;

  // block word
  localparam int SOFT_BIT = 31;
  localparam int GATE_BIT = 30;

  // channel word
  localparam int SEL_LSB  = 0;
  localparam int PRE_LSB  = 4;
  localparam int POL_BIT  = 6;
  localparam int UPD_BIT  = 7;
  localparam int REL_BIT  = 8;
  localparam int IEN_BIT  = 14;
  localparam int FLAG_BIT = 15;

  localparam logic [SEL_W-1:0] SEL_NEVER  = 4'd0;
  localparam logic [SEL_W-1:0] SEL_EXT    = 4'd1;
  localparam logic [SEL_W-1:0] SEL_REF    = 4'd8;
  localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'd15;

  typedef struct packed {
    logic chReset;   // hold channel cleared
    logic run;       // counting allowed
    logic cntWr;     // store fixed count
    logic loadLive;  // also load live count
    logic flagClr;   // clear sticky flag
    logic preClr;    // restart prescaler
  } dpCmd_t;
endpackage

// File: rtl/dtimer_ctrl.sv
module dtimer_ctrl
  import dtimer_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 wrEn,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [DATA_W-1:0]    wrData,
  input  logic [CNT_W-1:0]     liveCnt,
  input  logic [CNT_W-1:0]     fixedCnt,
  input  logic                 irqFlag,
  output logic [DATA_W-1:0]    rdData,
  output dpCmd_t               cmd,
  output logic [SEL_W-1:0]     sel,
  output logic [PRE_W-1:0]     prescale,
  output logic                 polarity,
  output logic                 reload,
  output logic                 irqEn,
  output logic                 softRst,
  output logic                 clkGate
);
  logic                updR;
  logic [ADDR_W-5:0]   page;
  logic [1:0]          kind;
  logic                aliasOk, blkHit, chHit, cntHit, chWr;
  logic [DATA_W-1:0]   blkWord, chWord, blkNew, chNew;

  assign page    = addr[ADDR_W-1:4];
  assign kind    = addr[3:2];
  assign aliasOk = (addr[1:0] == 2'b00) && (kind != 2'd3);
  assign blkHit  = aliasOk && (page == PAGE_BLK);
  assign chHit   = aliasOk && (page == PAGE_CH);
  assign cntHit  = (page == PAGE_CNT) && (addr[3:0] == 4'd0);

  function automatic logic [DATA_W-1:0] mergeWord(input logic [DATA_W-1:0] oldW,
                                                  input logic [DATA_W-1:0] data,
                                                  input logic [1:0] k);
    case (k)
      KIND_SET: mergeWord = oldW | data;
      KIND_CLR: mergeWord = oldW & ~data;
      default:  mergeWord = data;
    endcase
  endfunction

  always_comb begin
    blkWord = '0;
    blkWord[SOFT_BIT] = softRst;
    blkWord[GATE_BIT] = clkGate;
    chWord = '0;
    chWord[SEL_LSB +: SEL_W] = sel;
    chWord[PRE_LSB +: PRE_W] = prescale;
    chWord[POL_BIT]  = polarity;
    chWord[UPD_BIT]  = updR;
    chWord[REL_BIT]  = reload;
    chWord[IEN_BIT]  = irqEn;
    chWord[FLAG_BIT] = irqFlag;
  end

  assign blkNew = mergeWord(blkWord, wrData, kind);
  assign chNew  = mergeWord(chWord, wrData, kind);
  assign chWr   = wrEn && chHit && !softRst;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      softRst  <= 1'b1;
      clkGate  <= 1'b1;
      sel      <= SEL_NEVER;
      prescale <= '0;
      polarity <= 1'b0;
      updR     <= 1'b0;
      reload   <= 1'b0;
      irqEn    <= 1'b0;
    end else begin
      if (wrEn && blkHit) begin
        softRst <= blkNew[SOFT_BIT];
        clkGate <= blkNew[GATE_BIT];
      end
      if (softRst) begin
        sel      <= SEL_NEVER;
        prescale <= '0;
        polarity <= 1'b0;
        updR     <= 1'b0;
        reload   <= 1'b0;
        irqEn    <= 1'b0;
      end else if (chWr) begin
        sel      <= chNew[SEL_LSB +: SEL_W];
        prescale <= chNew[PRE_LSB +: PRE_W];
        polarity <= chNew[POL_BIT];
        updR     <= chNew[UPD_BIT];
        reload   <= chNew[REL_BIT];
        irqEn    <= chNew[IEN_BIT];
      end
    end
  end

  always_comb begin
    cmd.chReset  = softRst;
    cmd.run      = !softRst && !clkGate;
    cmd.cntWr    = wrEn && cntHit && !softRst;
    cmd.loadLive = cmd.cntWr && updR;
    cmd.flagClr  = chWr && (kind == KIND_CLR) && wrData[FLAG_BIT];
    cmd.preClr   = chWr;
  end

  always_comb begin
    if (blkHit)      rdData = blkWord;
    else if (chHit)  rdData = chWord;
    else if (cntHit) rdData = {liveCnt, fixedCnt};
    else             rdData = '0;
  end
endmodule

// File: rtl/dtimer_dp.sv
module dtimer_dp
  import dtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [CNT_W-1:0]  cntData,
  input  logic [SEL_W-1:0]  sel,
  input  logic [PRE_W-1:0]  prescale,
  input  logic              polarity,
  input  logic              reload,
  input  logic              extTick,
  input  logic              refTick,
  output logic [CNT_W-1:0]  liveCnt,
  output logic [CNT_W-1:0]  fixedCnt,
  output logic              irqFlag
);
  localparam int DIV_W = (1 << PRE_W) - 1;

  logic             pinIn, curIn, prevIn, edgeSeen, srcPulse, tick, expire;
  logic [DIV_W-1:0] divCnt, divMask;
  logic [CNT_W-1:0] nextCnt;

  always_comb begin
    case (sel)
      SEL_EXT: pinIn = extTick;
      SEL_REF: pinIn = refTick;
      default: pinIn = 1'b0;
    endcase
  end

  assign curIn    = pinIn ^ polarity;
  assign edgeSeen = curIn && !prevIn;
  assign srcPulse = (sel == SEL_ALWAYS) || (((sel == SEL_EXT) || (sel == SEL_REF)) && edgeSeen);
  assign divMask  = ~({DIV_W{1'b1}} << prescale);
  assign tick     = cmd.run && srcPulse && ((divCnt & divMask) == divMask);

  always_comb begin
    if (liveCnt != '0) nextCnt = liveCnt - 1'b1;
    else if (reload)   nextCnt = fixedCnt;
    else               nextCnt = '0;
  end

  assign expire = tick && (nextCnt == '0) && ((liveCnt != '0) || reload);

  always_ff @(posedge clk) begin
    if (!rstN || cmd.chReset) begin
      prevIn   <= 1'b0;
      divCnt   <= '0;
      liveCnt  <= '0;
      fixedCnt <= '0;
      irqFlag  <= 1'b0;
    end else begin
      prevIn <= curIn;
      if (cmd.preClr)                divCnt <= '0;
      else if (cmd.run && srcPulse)  divCnt <= divCnt + 1'b1;
      if (cmd.cntWr) fixedCnt <= cntData;
      if (cmd.loadLive)  liveCnt <= cntData;
      else if (tick)     liveCnt <= nextCnt;
      if (expire)            irqFlag <= 1'b1;
      else if (cmd.flagClr)  irqFlag <= 1'b0;
    end
  end
endmodule

// File: rtl/dtimer_channel.sv
module dtimer_channel
  import dtimer_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              extTick,
  input  logic              refTick,
  output logic              irq
);
  dpCmd_t           cmd;
  logic [SEL_W-1:0] sel;
  logic [PRE_W-1:0] prescale;
  logic             polarity, reload, irqEn, softRst, clkGate, irqFlag;
  logic [CNT_W-1:0] liveCnt, fixedCnt;

  dtimer_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .liveCnt(liveCnt), .fixedCnt(fixedCnt), .irqFlag(irqFlag),
    .rdData(rdData), .cmd(cmd), .sel(sel), .prescale(prescale),
    .polarity(polarity), .reload(reload), .irqEn(irqEn),
    .softRst(softRst), .clkGate(clkGate)
  );

  dtimer_dp u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .cntData(wrData[CNT_W-1:0]),
    .sel(sel), .prescale(prescale), .polarity(polarity), .reload(reload),
    .extTick(extTick), .refTick(refTick),
    .liveCnt(liveCnt), .fixedCnt(fixedCnt), .irqFlag(irqFlag)
  );

  assign irq = irqFlag && irqEn;
endmodule

// File: rtl/dtimer_checker.sv
module dtimer_checker
  import dtimer_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             softRst,
  input logic             clkGate,
  input dpCmd_t           cmd,
  input logic             reload,
  input logic             irqEn,
  input logic             irqFlag,
  input logic             irq,
  input logic [CNT_W-1:0] liveCnt
);
  assert_reset_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> (liveCnt == '0) && !irqFlag);

  assert_gate_freezes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clkGate && !softRst && !cmd.loadLive) |=> $stable(liveCnt));

  assert_no_count_up_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!reload && !cmd.loadLive && !softRst) |=> (liveCnt <= $past(liveCnt)));

  assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !cmd.flagClr && !softRst) |=> irqFlag);

  assert_irq_gated_R11: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (irqFlag && irqEn));
endmodule

bind dtimer_channel dtimer_checker u_chk (
  .clk(clk), .rstN(rstN), .softRst(softRst), .clkGate(clkGate), .cmd(cmd),
  .reload(reload), .irqEn(irqEn), .irqFlag(irqFlag), .irq(irq), .liveCnt(liveCnt)
);

// File: tb/dtimer_channel_test.sv
module dtimer_channel_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        extTick = 1'b0;
  logic        refTick = 1'b0;
  logic        irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  // behavioural model state
  int mSoft, mGate, mSel, mPre, mPol, mUpd, mRel, mIen, mFlag, mLive, mFixed, mDiv, mPrev;

  dtimer_channel uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .rdData(rdData), .extTick(extTick), .refTick(refTick), .irq(irq)
  );

  always #4 clk = ~clk;

  function automatic bit [31:0] chModel();
    return 32'(mSel) | 32'(mPre << 4) | 32'(mPol << 6) | 32'(mUpd << 7) |
           32'(mRel << 8) | 32'(mIen << 14) | 32'(mFlag << 15);
  endfunction

  function automatic bit [31:0] readModel(input bit [7:0] a);
    if (a == 8'h00 || a == 8'h04 || a == 8'h08) return (32'(mSoft) << 31) | (32'(mGate) << 30);
    if (a == 8'h10 || a == 8'h14 || a == 8'h18) return chModel();
    if (a == 8'h20) return (32'(mLive) << 16) | 32'(mFixed);
    return 32'h0;
  endfunction

  function automatic bit [31:0] mergeModel(input bit [31:0] o, input bit [31:0] d, input int k);
    if (k == 1) return o | d;
    if (k == 2) return o & ~d;
    return d;
  endfunction

  task automatic clearCh();
    mSel = 0; mPre = 0; mPol = 0; mUpd = 0; mRel = 0; mIen = 0;
    mFlag = 0; mLive = 0; mFixed = 0; mDiv = 0; mPrev = 0;
  endtask

  always @(posedge clk) begin
    if (!rstN) begin
      mSoft = 1; mGate = 1; clearCh();
    end else begin
      int pin, cur, pulse, run, mask, tick, nxt, setF, k, oldUpd;
      bit [31:0] w;
      pin = (mSel == 1) ? int'(extTick) : (mSel == 8) ? int'(refTick) : 0;
      cur = pin ^ mPol;
      pulse = (mSel == 15) || ((mSel == 1 || mSel == 8) && cur == 1 && mPrev == 0);
      run = (mSoft == 0) && (mGate == 0);
      mask = (1 << mPre) - 1;
      tick = run && pulse && ((mDiv & mask) == mask);
      k = int'(addr[3:2]);
      oldUpd = mUpd;
      if (mSoft != 0) begin
        clearCh();
      end else begin
        mPrev = cur;
        if (run && pulse) mDiv = (mDiv + 1) % 8;
        setF = 0;
        if (tick) begin
          nxt = (mLive != 0) ? mLive - 1 : (mRel != 0 ? mFixed : 0);
          if (nxt == 0 && (mLive != 0 || mRel != 0)) setF = 1;
          mLive = nxt;
        end
        if (wrEn && addr == 8'h20) begin
          mFixed = int'(wrData[15:0]);
          if (oldUpd != 0) mLive = int'(wrData[15:0]);
        end
        if (wrEn && addr[7:4] == 4'h1 && addr[1:0] == 2'b00 && k != 3) begin
          w = mergeModel(chModel(), wrData, k);
          mSel = int'(w[3:0]); mPre = int'(w[5:4]); mPol = int'(w[6]);
          mUpd = int'(w[7]); mRel = int'(w[8]); mIen = int'(w[14]);
          if (k == 2 && wrData[15]) mFlag = 0;
          mDiv = 0;
        end
        if (setF != 0) mFlag = 1;
      end
      if (wrEn && addr[7:4] == 4'h0 && addr[1:0] == 2'b00 && k != 3) begin
        w = mergeModel((32'(mSoft) << 31) | (32'(mGate) << 30), wrData, k);
        mSoft = int'(w[31]); mGate = int'(w[30]);
      end
    end
  end

  task automatic check(input bit ok, input string req, input bit [31:0] act, input bit [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  // per-clock comparison of the interrupt output (R11)
  always @(negedge clk) begin
    if (rstN && !done) check(irq == ((mFlag != 0) && (mIen != 0)), "R11 irq", 32'(irq), 32'(mFlag & mIen));
  end

  task automatic wr(input bit [7:0] a, input bit [31:0] d);
    @(negedge clk); wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk); wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(input bit [7:0] a, input string req);
    @(negedge clk); addr = a; #1;
    check(rdData == readModel(a), req, rdData, readModel(a));
  endtask

  task automatic rdLit(input bit [7:0] a, input bit [31:0] exp, input string req);
    @(negedge clk); addr = a; #1;
    check(rdData == exp, req, rdData, exp);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulsePin(input bit isExt, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); if (isExt) extTick = ~extTick; else refTick = ~refTick;
      @(negedge clk); if (isExt) extTick = ~extTick; else refTick = ~refTick;
    end
  endtask

  task automatic finishRun();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset values
    rdLit(8'h00, 32'hC000_0000, "R1 block word");
    rdLit(8'h10, 32'h0, "R1 channel word");
    rdLit(8'h20, 32'h0, "R1 count word");
    check(irq == 1'b0, "R1 irq", 32'(irq), 32'h0);
    // R2 writes ignored under soft reset
    wr(8'h20, 32'h5);
    rdLit(8'h20, 32'h0, "R2 count write ignored");
    wr(8'h08, 32'hC000_0000);
    rdLit(8'h00, 32'h0, "R2 R12 block clear alias");
    rdLit(8'h3C, 32'h0, "R12 unmapped read");
    // R7 R10 one-shot every clock, update on, irq enabled
    wr(8'h10, 32'h0000_408F);
    wr(8'h20, 32'h5);
    idle(10);
    rdLit(8'h20, 32'h0000_0005, "R7 stopped at zero");
    check(irq == 1'b1, "R10 flag raised", 32'(irq), 32'h1);
    // R11 enable gating, R12 aliases
    wr(8'h18, 32'h0000_4000);
    check(irq == 1'b0, "R11 enable cleared", 32'(irq), 32'h0);
    rdLit(8'h10, 32'h0000_808F, "R11 flag kept");
    wr(8'h14, 32'h0000_4000);
    check(irq == 1'b1, "R11 enable set", 32'(irq), 32'h1);
    wr(8'h10, 32'h0000_C08F);
    rdLit(8'h10, 32'h0000_C08F, "R12 base write leaves flag");
    wr(8'h18, 32'h0000_8000);
    rdLit(8'h14, 32'h0000_408F, "R12 flag cleared via clear alias");
    // R9 update off
    wr(8'h18, 32'h0000_0080);
    wr(8'h20, 32'h1234);
    rdLit(8'h20, 32'h0000_1234, "R9 fixed only");
    // R9 maximum count with update on: one tick between load and read
    wr(8'h14, 32'h0000_0080);
    wr(8'h20, 32'hFFFF);
    rdLit(8'h20, 32'hFFFE_FFFF, "R9 max load");
    // R8 reload with period 3
    wr(8'h14, 32'h0000_0100);
    wr(8'h20, 32'h2);
    for (int i = 0; i < 8; i++) rd(8'h20, "R8 reload cycle");
    wr(8'h18, 32'h0000_8000);
    // R6 prescale 2 and 3
    wr(8'h20, 32'h7);
    wr(8'h14, 32'h0000_0020);
    for (int i = 0; i < 12; i++) rd(8'h20, "R6 prescale 2");
    wr(8'h14, 32'h0000_0030);
    for (int i = 0; i < 12; i++) rd(8'h20, "R6 prescale 3");
    wr(8'h18, 32'h0000_0030);
    // R3 clock gate
    wr(8'h04, 32'h4000_0000);
    rd(8'h20, "R3 gated a");
    idle(5);
    rd(8'h20, "R3 gated b");
    wr(8'h20, 32'h9);
    rd(8'h20, "R3 write while gated");
    wr(8'h08, 32'h4000_0000);
    rd(8'h20, "R3 resumed");
    // R4 never tick
    wr(8'h18, 32'h0000_000F);
    wr(8'h20, 32'h6);
    idle(6);
    rdLit(8'h20, 32'h0006_0006, "R4 never tick holds");
    // R4 external pin, R5 polarity
    wr(8'h14, 32'h0000_0001);
    pulsePin(1'b1, 3);
    rd(8'h20, "R4 external edges");
    wr(8'h14, 32'h0000_0040);
    pulsePin(1'b1, 2);
    @(negedge clk); extTick = 1'b1;
    rd(8'h20, "R5 inverted pin held high");
    @(negedge clk); extTick = 1'b0;
    rd(8'h20, "R5 inverted falling edge");
    // R4 reference pin
    wr(8'h10, 32'h0000_4188);
    wr(8'h20, 32'h3);
    pulsePin(1'b0, 5);
    rd(8'h20, "R4 reference edges");
    rd(8'h10, "R10 reference expiry flag");
    wr(8'h10, 32'h0000_418B);
    pulsePin(1'b0, 2);
    rd(8'h20, "R4 unused code never ticks");
    // R2 soft reset mid-run
    wr(8'h10, 32'h0000_418F);
    wr(8'h04, 32'h8000_0000);
    idle(2);
    rdLit(8'h10, 32'h0, "R2 channel cleared");
    rdLit(8'h20, 32'h0, "R2 count cleared");
    wr(8'h08, 32'h8000_0000);
    rd(8'h00, "R2 block running");
    idle(2);
    finishRun();
  end
endmodule